// File: doc/BRIEF.md
# Latched Edge Interrupt Controller

This block raises a host interrupt request from a single external digital input on a small I/O card. A two-stage synchroniser brings the input into the card clock domain, and a rising edge on the synchronised signal sets a pending latch. The latch holds until software clears it. While the latch is set, further edges are dropped; they are not counted or queued.

Software controls the block only through side effects of bus cycles to two fixed offsets, and the data value plays no part. A write to the enable offset arms the block and a read from the same offset disarms it. A write to the clear offset releases the pending latch. A two-bit mode input gates the request in one of three ways: always open, open only while a gating port bit is low, or closed. The gated request goes out on exactly one line of a bank of host interrupt lines, and an elaboration-time parameter picks that line.

The block carries no data, so it has no valid/ready stream. Every pin is plain control.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset the enable flag is clear, nothing is pending, and every bit of `irq_lines` is 0.
- R2: A write strobe with `bus_cs`=1 to offset 0xB sets the enable flag. A read strobe with `bus_cs`=1 to offset 0xB clears it, and the request drops at the next clock edge.
- R3: When the block is armed (enable set and gate open), a rising edge on `ext_in` sets the pending latch. The request is visible after the third rising clock edge that follows `ext_in` going high (two synchroniser stages, then the latch).
- R4: The pending latch holds while `ext_in` stays high or toggles. Edges that arrive while it is set are dropped, so after a clear no request appears without a new edge.
- R5: A write strobe with `bus_cs`=1 to offset 0xF clears the pending latch, and the request is low after the next clock edge.
- R6: `gate_mode` encoding: 2'b01 is always open. 2'b10 is open only while `port_c7` is 0. 2'b00 and 2'b11 are closed. A closed gate holds the request low whatever the enable flag says.
- R7: The request appears only on `irq_lines[ROUTE_LEVEL]` (default 5), and all other bits stay 0. ROUTE_LEVEL must be one of 2–7 or 10–12; any other value leaves every line at 0.
- R8: A strobe with `bus_cs`=0, or a strobe to any offset other than 0xB and 0xF, has no effect. A read of 0xF also has no effect.
- R9: Each strobe acts once, on its rising edge. A held write to 0xF clears the latch once only, and an edge that arrives later during the same strobe is latched.
- R10: An edge that arrives while the block is disarmed (enable clear or gate closed) is not latched. Arming the block afterwards raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Offset from the card base |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_cs | input | 1 | Card select, active high |
| gate_mode | input | 2 | Request gating mode (see R6) |
| port_c7 | input | 1 | Gating bit from the I/O port, active low |
| ext_in | input | 1 | External interrupt input, asynchronous |
| irq_lines | output | 16 | Host interrupt lines, at most one bit high |

## Verification
The assertions check on every cycle that the latch is sticky until a clear and drops right after one. They also check that the enable flag follows the set and clear strobes, that a disarmed block never latches, that a closed mode keeps the request low, that a strobe event never lasts two cycles, and that no more than one host line is high. Only the bench scenarios can show the things that depend on history across several accesses. These are the exact latency from pin to request, that edges during a pending request are dropped and not queued, that a held clear strobe still lets a later edge latch, and that accesses with chip select low or to foreign offsets change nothing visible. The bench sweeps every combination of mode, port bit and enable.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  typedef enum logic [1:0] {
    GATE_OFF    = 2'b00,
    GATE_ALWAYS = 2'b01,
    GATE_PORT   = 2'b10,
    GATE_RSVD   = 2'b11
  } gate_mode_e;

  function automatic bit level_ok(input int lvl);
    return (lvl >= 2 && lvl <= 7) || (lvl >= 10 && lvl <= 12);
  endfunction

endpackage

// File: rtl/lirq_sync_edge.sv
module lirq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/lirq_bus_decode.sv
module lirq_bus_decode #(
  parameter int          ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] OFF_EN  = 4'hB,
  parameter logic [ADDR_W-1:0] OFF_CLR = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              cs,
  output logic              en_set,
  output logic              en_clr,
  output logic              pend_clr
);
  logic rd_live, wr_live, rd_q, wr_q, rd_evt, wr_evt;

  assign rd_live = rd & cs;
  assign wr_live = wr & cs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_live;
      wr_q <= wr_live;
    end
  end

  assign rd_evt   = rd_live & ~rd_q;
  assign wr_evt   = wr_live & ~wr_q;
  assign en_set   = wr_evt & (addr == OFF_EN);
  assign en_clr   = rd_evt & (addr == OFF_EN);
  assign pend_clr = wr_evt & (addr == OFF_CLR);

  // R9: one event per strobe
  p_one_shot_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  p_one_shot_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);
  p_need_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !(en_set || en_clr || pend_clr));

endmodule

// File: rtl/lirq_core.sv
module lirq_core
  import lirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       pend_clr,
  input  logic       rise,
  input  logic [1:0] mode,
  input  logic       port_c7,
  output logic       req
);
  logic enable, pending, gate_open, armed;

  always_comb begin
    case (gate_mode_e'(mode))
      GATE_ALWAYS: gate_open = 1'b1;
      GATE_PORT:   gate_open = ~port_c7;
      default:     gate_open = 1'b0;
    endcase
  end

  assign armed = enable & gate_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (en_clr)      enable <= 1'b0;
      else if (en_set) enable <= 1'b1;
      if (pend_clr)            pending <= 1'b0;
      else if (rise && armed)  pending <= 1'b1;
    end
  end

  assign req = pending & armed;

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pending);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !pend_clr |=> pending);
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set && !en_clr |=> enable);
  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !enable);
  p_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !pending |=> !pending);
  p_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !req);

endmodule

// File: rtl/lirq_route.sv
module lirq_route
  import lirq_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int ROUTE_LEVEL = 5
) (
  input  logic                 req,
  output logic [NUM_LINES-1:0] lines
);
  localparam bit LEGAL = level_ok(ROUTE_LEVEL) && (ROUTE_LEVEL < NUM_LINES);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (LEGAL && i == ROUTE_LEVEL) begin : g_hit
      assign lines[i] = req;
    end else begin : g_miss
      assign lines[i] = 1'b0;
    end
  end

endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl #(
  parameter int NUM_LINES   = 16,
  parameter int ROUTE_LEVEL = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic                 bus_cs,
  input  logic [1:0]           gate_mode,
  input  logic                 port_c7,
  input  logic                 ext_in,
  output logic [NUM_LINES-1:0] irq_lines
);
  logic rise, en_set, en_clr, pend_clr, req;

  lirq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .rise(rise)
  );

  lirq_bus_decode #(.ADDR_W(4), .OFF_EN(4'hB), .OFF_CLR(4'hF)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .cs(bus_cs), .en_set(en_set), .en_clr(en_clr), .pend_clr(pend_clr)
  );

  lirq_core u_core (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .pend_clr(pend_clr), .rise(rise), .mode(gate_mode), .port_c7(port_c7),
    .req(req)
  );

  lirq_route #(.NUM_LINES(NUM_LINES), .ROUTE_LEVEL(ROUTE_LEVEL)) u_route (
    .req(req), .lines(irq_lines)
  );

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
  p_drop_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> irq_lines == '0);

endmodule

// File: tb/tb_lirq_ctrl.sv
module tb_lirq_ctrl;
  localparam int LVL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_cs = 1'b0;
  logic [1:0]  gate_mode = 2'b00;
  logic        port_c7 = 1'b0;
  logic        ext_in = 1'b0;
  logic [15:0] irq_lines;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lirq_ctrl #(.ROUTE_LEVEL(LVL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_cs(bus_cs), .gate_mode(gate_mode),
    .port_c7(port_c7), .ext_in(ext_in), .irq_lines(irq_lines)
  );

  task automatic check(input string tag, input bit exp_req);
    logic [15:0] exp;
    exp = exp_req ? (16'h1 << LVL) : 16'h0;
    checks++;
    if (irq_lines !== exp) begin
      errors++;
      $display("FAIL %s irq_lines=%h expected=%h", tag, irq_lines, exp);
    end
  endtask

  task automatic access(input bit is_wr, input logic [3:0] a, input bit cs, input int hold);
    bus_addr = a; bus_cs = cs; bus_wr = is_wr; bus_rd = !is_wr;
    repeat (hold) @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ext();
    ext_in = 1'b1;
    repeat (4) @(negedge clk);
    ext_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit gate_of(input logic [1:0] m, input logic c7);
    return (m == 2'b01) || (m == 2'b10 && !c7);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0);

    // R3 latency: request after third clock edge
    gate_mode = 2'b01;
    access(1'b1, 4'hB, 1'b1, 1);
    ext_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 not before third edge", 1'b0);
    @(negedge clk);
    check("R3 latched at third edge", 1'b1);
    ext_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 held after input low", 1'b1);

    // R4: edges during pending are dropped
    pulse_ext();
    access(1'b1, 4'hF, 1'b1, 1);
    check("R5 clear drops request", 1'b0);
    repeat (4) @(negedge clk);
    check("R4 no queued edge", 1'b0);

    // R2 / R8 via a latched request
    pulse_ext();
    check("R3 relatched", 1'b1);
    access(1'b0, 4'hB, 1'b1, 1);
    check("R2 read disables", 1'b0);
    access(1'b1, 4'hB, 1'b0, 1);
    check("R8 no cs ignored", 1'b0);
    access(1'b1, 4'hA, 1'b1, 1);
    check("R8 foreign offset ignored", 1'b0);
    access(1'b1, 4'hB, 1'b1, 1);
    check("R2 write enables, pending kept", 1'b1);
    access(1'b0, 4'hF, 1'b1, 1);
    check("R8 read of clear offset ignored", 1'b1);
    access(1'b1, 4'hF, 1'b0, 1);
    check("R8 clear without cs ignored", 1'b1);

    // R9: held clear strobe acts once
    bus_addr = 4'hF; bus_cs = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    check("R5 clear at strobe start", 1'b0);
    ext_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 edge latched during held clear", 1'b1);
    bus_wr = 1'b0; bus_cs = 1'b0; ext_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 still pending after strobe", 1'b1);

    // R6/R10 sweep over mode, port bit, enable
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int e = 0; e < 2; e++) begin
          gate_mode = 2'(m); port_c7 = 1'(c);
          access(1'b1, 4'hF, 1'b1, 1);
          if (e != 0) access(1'b1, 4'hB, 1'b1, 1);
          else        access(1'b0, 4'hB, 1'b1, 1);
          pulse_ext();
          check($sformatf("R6 mode=%0d c7=%0d en=%0d", m, c, e),
                (e != 0) && gate_of(2'(m), 1'(c)));
          if (!((e != 0) && gate_of(2'(m), 1'(c)))) begin
            gate_mode = 2'b01;
            access(1'b1, 4'hB, 1'b1, 1);
            check($sformatf("R10 no late fire mode=%0d c7=%0d en=%0d", m, c, e), 1'b0);
          end else begin
            gate_mode = 2'b00;
            @(negedge clk);
            check("R6 closing gate masks", 1'b0);
            gate_mode = 2'(m);
            @(negedge clk);
            check("R6 reopening restores", 1'b1);
          end
        end
      end
    end

    // R7 routing under a port-gated request
    gate_mode = 2'b10; port_c7 = 1'b0;
    access(1'b1, 4'hF, 1'b1, 1);
    access(1'b1, 4'hB, 1'b1, 1);
    pulse_ext();
    check("R7 only routed line", 1'b1);
    port_c7 = 1'b1;
    @(negedge clk);
    check("R6 port bit high blocks", 1'b0);

    finish_run();
  end
endmodule